// File: doc/BRIEF.md
# Operand Pattern Trap Checker

This block watches the two source operands of an instruction while the ALU works on them. It compares them against one of several programmable rule sets. Each rule set has three parts. A mask picks the operand bits that matter. A compare word gives the values those bits are expected to hold. A polarity bit decides whether a match or a mismatch is the trap condition. The check reads only the instruction's inputs, so it runs in parallel with the ALU and never waits for the ALU result. Runtimes for dynamically typed languages can use it to catch operands whose tag bits are unexpected.

Software loads the rule sets through a one-cycle register-write port. Each checking instruction raises `chkEn`, chooses a rule set with `chkSet` and presents both operands. A trap request appears in the same cycle. At the next clock edge the block records which rule set fired and which operands hit. That record stays until software clears it.

Top module: `operand_trap_guard`

## Requirements
- R1: After reset, every mask, compare word and polarity bit is zero, so no check raises a trap, and `trapValid` is 0.
- R2: When `cfgWrEn` is 1, the register that `cfgWrSel` names in rule set `cfgWrSet` takes `cfgWrData` at the clock edge. Select 0 writes the mask, 1 writes the compare word and 2 writes the polarity bit from `cfgWrData[0]`. Select 3 changes no register.
- R3: With polarity 1, an operand hits when its masked bits equal the masked compare word.
- R4: With polarity 0, an operand hits when its masked bits differ from the masked compare word.
- R5: Operand bits where the mask is 0 never change whether that operand hits.
- R6: `trapReq` is 1 in the same cycle exactly when `chkEn` is 1 and at least one operand hits. When `chkEn` is 0, `trapReq` is 0 and no record is taken.
- R7: Only the rule set that `chkSet` selects is used for a check.
- R8: At the edge that ends a cycle with `trapReq` = 1 while no record is held, the block sets `trapValid`, stores `chkSet` in `trapSet` and stores the hits in `trapWhich`. Bit 0 of `trapWhich` is operand A and bit 1 is operand B. While a record is held and `clrTrap` is 0, later traps leave it unchanged.
- R9: `clrTrap` drops `trapValid` at the next edge and leaves `trapSet` and `trapWhich` as they were. If `trapReq` is 1 in the same cycle, the new trap is recorded instead.
- R10: A check in the same cycle as a register write uses the contents from before the write. The new value applies from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgWrSel | input | 2 | Register select: 0 mask, 1 compare, 2 polarity, 3 none |
| cfgWrSet | input | SET_W | Rule set addressed by the write |
| cfgWrData | input | DATA_W | Write data |
| chkEn | input | 1 | Instruction requests a check |
| chkSet | input | SET_W | Rule set used by the check |
| opA | input | DATA_W | First source operand |
| opB | input | DATA_W | Second source operand |
| clrTrap | input | 1 | Clear the held trap record |
| trapReq | output | 1 | Trap request for the current check |
| trapValid | output | 1 | A trap record is held |
| trapSet | output | SET_W | Rule set of the held record |
| trapWhich | output | 2 | Operands that hit: bit 0 A, bit 1 B |

## Verification
Two pairs of actions can fall in the same cycle. The first pair is a register write and a check on the same rule set. The bench writes a mask into a set while checking that set with an operand that only the new mask would catch. It expects no trap in that cycle and a trap in the next one, which is where R10 places it. The second pair is a clear and a fresh trap. The bench raises `clrTrap` in the cycle of a new trap on a different rule set. The record must then show the new set and the new operand hits rather than going empty.

// File: rtl/opguard_pkg.sv
package opguard_pkg;

  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_CMP  = 2'd1,
    SEL_POL  = 2'd2,
    SEL_NONE = 2'd3
  } cfgSel_e;

  typedef struct packed {
    logic wrMask;
    logic wrCmp;
    logic wrPol;
    logic capture;
    logic clear;
  } guardStrobe_t;

endpackage

// File: rtl/guard_ctrl.sv
module guard_ctrl
  import opguard_pkg::*;
(
  input  logic         cfgWrEn,
  input  logic [1:0]   cfgWrSel,
  input  logic         chkEn,
  input  logic [1:0]   hitVec,
  input  logic         trapValid,
  input  logic         clrTrap,
  output logic         trapReq,
  output guardStrobe_t strb
);

  always_comb begin
    strb = '0;
    if (cfgWrEn) begin
      unique case (cfgSel_e'(cfgWrSel))
        SEL_MASK: strb.wrMask = 1'b1;
        SEL_CMP:  strb.wrCmp  = 1'b1;
        SEL_POL:  strb.wrPol  = 1'b1;
        default:  ;
      endcase
    end
    trapReq      = chkEn & (|hitVec);
    strb.capture = trapReq & (~trapValid | clrTrap);
    strb.clear   = clrTrap;
  end

endmodule

// File: rtl/guard_dp.sv
module guard_dp
  import opguard_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_SETS = 4,
  parameter int SET_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  guardStrobe_t      strb,
  input  logic [SET_W-1:0]  cfgWrSet,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic [SET_W-1:0]  chkSet,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [1:0]        hitVec,
  output logic              trapValid,
  output logic [SET_W-1:0]  trapSet,
  output logic [1:0]        trapWhich
);

  localparam int NUM_OPS = 2;

  logic [DATA_W-1:0] maskReg [NUM_SETS];
  logic [DATA_W-1:0] cmpReg  [NUM_SETS];
  logic              polReg  [NUM_SETS];

  // One register bank per rule set
  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic selHere;
    assign selHere = (cfgWrSet == SET_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        maskReg[s] <= '0;
        cmpReg[s]  <= '0;
        polReg[s]  <= 1'b0;
      end else if (selHere) begin
        if (strb.wrMask) maskReg[s] <= cfgWrData;
        if (strb.wrCmp)  cmpReg[s]  <= cfgWrData;
        if (strb.wrPol)  polReg[s]  <= cfgWrData[0];
      end
    end
  end

  logic [DATA_W-1:0] curMask;
  logic [DATA_W-1:0] curCmp;
  logic              curPol;

  always_comb begin
    curMask = maskReg[chkSet];
    curCmp  = cmpReg[chkSet];
    curPol  = polReg[chkSet];
  end

  logic [DATA_W-1:0] opVec [NUM_OPS];
  assign opVec[0] = opA;
  assign opVec[1] = opB;

  // One comparator tree per operand
  for (genvar o = 0; o < NUM_OPS; o++) begin : g_op
    logic [DATA_W-1:0] diffBits;
    logic              sameBits;
    assign diffBits  = (opVec[o] ^ curCmp) & curMask;
    assign sameBits  = ~|diffBits;
    assign hitVec[o] = curPol ? sameBits : ~sameBits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trapValid <= 1'b0;
      trapSet   <= '0;
      trapWhich <= '0;
    end else if (strb.capture) begin
      trapValid <= 1'b1;
      trapSet   <= chkSet;
      trapWhich <= hitVec;
    end else if (strb.clear) begin
      trapValid <= 1'b0;
    end
  end

endmodule

// File: rtl/operand_trap_guard.sv
module operand_trap_guard
  import opguard_pkg::*;
#(
  parameter int  DATA_W   = 32,
  parameter int  NUM_SETS = 4,
  localparam int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgWrSel,
  input  logic [SET_W-1:0]  cfgWrSet,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic              chkEn,
  input  logic [SET_W-1:0]  chkSet,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              clrTrap,
  output logic              trapReq,
  output logic              trapValid,
  output logic [SET_W-1:0]  trapSet,
  output logic [1:0]        trapWhich
);

  guardStrobe_t strb;
  logic [1:0]   hitVec;

  guard_ctrl u_ctrl (
    .cfgWrEn   (cfgWrEn),
    .cfgWrSel  (cfgWrSel),
    .chkEn     (chkEn),
    .hitVec    (hitVec),
    .trapValid (trapValid),
    .clrTrap   (clrTrap),
    .trapReq   (trapReq),
    .strb      (strb)
  );

  guard_dp #(
    .DATA_W   (DATA_W),
    .NUM_SETS (NUM_SETS),
    .SET_W    (SET_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .cfgWrSet  (cfgWrSet),
    .cfgWrData (cfgWrData),
    .chkSet    (chkSet),
    .opA       (opA),
    .opB       (opB),
    .hitVec    (hitVec),
    .trapValid (trapValid),
    .trapSet   (trapSet),
    .trapWhich (trapWhich)
  );

endmodule

// File: rtl/guard_chk.sv
module guard_chk #(
  parameter int SET_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chkEn,
  input logic [SET_W-1:0] chkSet,
  input logic             clrTrap,
  input logic             trapReq,
  input logic             trapValid,
  input logic [SET_W-1:0] trapSet,
  input logic [1:0]       trapWhich
);

  // R6: no request without a check
  a_r6_no_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !chkEn |-> !trapReq);

  // R6: a request without a held record always produces one
  a_r6_req_records: assert property (@(posedge clk) disable iff (!rst_n)
    (trapReq && !trapValid) |=> trapValid);

  // R8: a fresh record stores the checked set
  a_r8_set_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (trapReq && !trapValid) |=> (trapSet == $past(chkSet)));

  // R8: a held record is frozen until cleared
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (trapValid && !clrTrap) |=> (trapValid && $stable(trapSet) && $stable(trapWhich)));

  // R8: a held record names at least one operand
  a_r8_which_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    trapValid |-> (trapWhich != 2'b00));

  // R9: clear without a new trap empties the record
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clrTrap && !trapReq) |=> !trapValid);

  // R9: clear with a new trap keeps a record
  a_r9_clear_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (clrTrap && trapReq) |=> (trapValid && trapSet == $past(chkSet)));

endmodule

bind operand_trap_guard guard_chk #(.SET_W(SET_W)) u_guardChk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chkEn     (chkEn),
  .chkSet    (chkSet),
  .clrTrap   (clrTrap),
  .trapReq   (trapReq),
  .trapValid (trapValid),
  .trapSet   (trapSet),
  .trapWhich (trapWhich)
);

// File: tb/sim_operand_trap_guard.sv
`timescale 1ns/1ps
module sim_operand_trap_guard;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgWrSel = '0;
  logic [1:0]  cfgWrSet = '0;
  logic [31:0] cfgWrData = '0;
  logic        chkEn = 1'b0;
  logic [1:0]  chkSet = '0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        clrTrap = 1'b0;
  logic        trapReq;
  logic        trapValid;
  logic [1:0]  trapSet;
  logic [1:0]  trapWhich;

  always #5 clk = ~clk;

  operand_trap_guard u0 (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel),
    .cfgWrSet(cfgWrSet), .cfgWrData(cfgWrData), .chkEn(chkEn), .chkSet(chkSet),
    .opA(opA), .opB(opB), .clrTrap(clrTrap), .trapReq(trapReq),
    .trapValid(trapValid), .trapSet(trapSet), .trapWhich(trapWhich)
  );

  typedef struct {
    logic       req;
    logic       valid;
    logic [1:0] set;
    logic [1:0] which;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference state
  logic [31:0] mMask [4];
  logic [31:0] mCmp  [4];
  logic        mPol  [4];
  logic        mValid = 1'b0;
  logic [1:0]  mSet = '0;
  logic [1:0]  mWhich = '0;

  function automatic logic modelHit(input logic [1:0] s, input logic [31:0] v);
    logic eq;
    eq = ((v & mMask[s]) == (mCmp[s] & mMask[s]));
    return mPol[s] ? eq : !eq;
  endfunction

  task automatic step(input logic we, input logic [1:0] ws, input logic [1:0] wset,
                      input logic [31:0] wd, input logic en, input logic [1:0] cs,
                      input logic [31:0] a, input logic [31:0] b, input logic clr,
                      input string tag);
    expItem_t it;
    logic hA, hB;
    @(posedge clk); #2;
    cfgWrEn = we; cfgWrSel = ws; cfgWrSet = wset; cfgWrData = wd;
    chkEn = en; chkSet = cs; opA = a; opB = b; clrTrap = clr;
    hA = modelHit(cs, a);
    hB = modelHit(cs, b);
    it.req = en & (hA | hB);
    it.valid = mValid; it.set = mSet; it.which = mWhich; it.tag = tag;
    expQ.push_back(it);
    if (it.req && (!mValid || clr)) begin
      mValid = 1'b1; mSet = cs; mWhich = {hB, hA};
    end else if (clr) begin
      mValid = 1'b0;
    end
    if (we) begin
      case (ws)
        2'd0: mMask[wset] = wd;
        2'd1: mCmp[wset]  = wd;
        2'd2: mPol[wset]  = wd[0];
        default: ;
      endcase
    end
  endtask

  task automatic cfg(input logic [1:0] s, input logic [1:0] sel, input logic [31:0] d, input string tag);
    step(1'b1, sel, s, d, 1'b0, 2'd0, 32'd0, 32'd0, 1'b0, tag);
  endtask

  task automatic chk(input logic [1:0] s, input logic [31:0] a, input logic [31:0] b,
                     input logic clr, input string tag);
    step(1'b0, 2'd0, 2'd0, 32'd0, 1'b1, s, a, b, clr, tag);
  endtask

  task automatic idle(input logic clr, input string tag);
    step(1'b0, 2'd0, 2'd0, 32'd0, 1'b0, 2'd0, 32'd0, 32'd0, clr, tag);
  endtask

  // Monitor: scoreboard comparison away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        checks++;
        if (trapReq !== it.req || trapValid !== it.valid ||
            (it.valid && (trapSet !== it.set || trapWhich !== it.which))) begin
          errors++;
          $display("FAIL %s: got req=%b valid=%b set=%0d which=%b, expected req=%b valid=%b set=%0d which=%b",
                   it.tag, trapReq, trapValid, trapSet, trapWhich,
                   it.req, it.valid, it.set, it.which);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      mMask[i] = '0; mCmp[i] = '0; mPol[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (trapValid !== 1'b0 || trapReq !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: got valid=%b req=%b, expected 0 0", trapValid, trapReq);
    end

    // R1: reset contents never trap, on any set
    chk(2'd0, 32'hDEADBEEF, 32'h12345678, 1'b0, "R1 set0 after reset");
    chk(2'd3, 32'hFFFFFFFF, 32'h00000000, 1'b0, "R1 set3 after reset");

    // R2/R3: set1 traps when low two bits are 11
    cfg(2'd1, 2'd0, 32'h0000_0003, "R2 write mask set1");
    cfg(2'd1, 2'd1, 32'h0000_0003, "R2 write compare set1");
    cfg(2'd1, 2'd2, 32'h0000_0001, "R2 write polarity set1");
    chk(2'd1, 32'h0000_1003, 32'h0000_0002, 1'b0, "R3 equal on opA");
    idle(1'b0, "R8 record set1 opA");
    idle(1'b1, "R9 clear request");
    idle(1'b0, "R9 record cleared");

    // R4/R5: set2 traps when top nibble differs from A
    cfg(2'd2, 2'd0, 32'hF000_0000, "R2 write mask set2");
    cfg(2'd2, 2'd1, 32'hA000_0000, "R2 write compare set2");
    chk(2'd2, 32'hA123_4567, 32'hAFFF_FFFF, 1'b0, "R5 unmasked bits ignored");
    chk(2'd2, 32'hA000_0000, 32'h5000_0000, 1'b0, "R4 differ on opB");
    idle(1'b1, "R8 record set2 opB, clear");

    // R3: both operands hit
    chk(2'd1, 32'h0000_0007, 32'hFFFF_FFFF, 1'b0, "R3 both operands");
    idle(1'b1, "R8 record which=11, clear");

    // R7: same operands, different sets
    chk(2'd2, 32'h0000_0003, 32'h0000_0003, 1'b0, "R7 set2 sees mismatch");
    idle(1'b1, "R7 record set2, clear");
    chk(2'd0, 32'h0000_0003, 32'h0000_0003, 1'b0, "R7 set0 stays quiet");

    // R6: no check enabled with trapping operands
    step(1'b0, 2'd0, 2'd0, 32'd0, 1'b0, 2'd1, 32'h3, 32'h3, 1'b0, "R6 chkEn low");
    idle(1'b0, "R6 no record taken");

    // R8: first trap held over a later one
    chk(2'd1, 32'h0000_0003, 32'h0000_0000, 1'b0, "R8 first trap");
    chk(2'd2, 32'h0000_0000, 32'h0000_0000, 1'b0, "R8 second trap while held");
    idle(1'b0, "R8 record still first");

    // R9: clear together with a new trap
    chk(2'd2, 32'hA000_0000, 32'h1000_0000, 1'b1, "R9 clear with new trap");
    idle(1'b1, "R9 new record, clear");
    idle(1'b0, "R9 empty");

    // R10: write and check of the same set in one cycle
    cfg(2'd3, 2'd1, 32'h0000_0000, "R2 compare set3 zero");
    step(1'b1, 2'd0, 2'd3, 32'h0000_000F, 1'b1, 2'd3, 32'h1, 32'h0, 1'b0, "R10 old mask used");
    chk(2'd3, 32'h0000_0001, 32'h0000_0000, 1'b0, "R10 new mask applies");
    idle(1'b1, "R10 record set3, clear");

    // R2: select 3 writes nothing
    cfg(2'd3, 2'd3, 32'hFFFF_FFFF, "R2 select 3 write");
    chk(2'd3, 32'h0000_0000, 32'h0000_0000, 1'b0, "R2 set3 unchanged");
    chk(2'd3, 32'h0000_0100, 32'h0000_0000, 1'b0, "R2 set3 mask unchanged");
    idle(1'b0, "R2 final");

    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule